// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a configuration register file that a host reaches through two byte-wide I/O ports on a legacy 10-bit address bus. After reset the file is closed. The host opens it by writing a fixed key byte twice in a row to the index port. While the file is open, the host writes an index to the index port, then reads or writes the selected register through the data port. Writing a second key byte to the index port closes the file again.

Indices below 30h reach a small set of global registers. Indices from 30h upward reach the register bank of the logical device whose number is held in global register 07h. One global register holds a lock bit and a bit that moves the port pair to a second address. Every stored field drives a parallel output, so the rest of the chip sees the configuration directly. Each device bank carries an activate bit, a 16-bit base address, a 4-bit interrupt select and an 8-bit option byte.

Top module: `cfgk_key_port`

## Requirements
- R1: The file opens (cfg_mode_o = 1) in the cycle after the second of two successive writes of 83h to the index port.
- R2: A write of any other kind on the bus between the two key writes cancels the first key write, and a further two 83h writes are then needed.
- R3: The index port is at 2Eh and the data port at 2Fh. When bit 6 of global register 26h is 1, the pair moves to 4Eh/4Fh, and accesses to 2Eh/2Fh then have no effect.
- R4: While the file is open, a write of AAh to the index port closes it. Any data port write made while the file is closed changes no register.
- R5: The index port is write-only and reads as FFh. The data port both reads and writes the register that the index selects.
- R6: Indices 00h–2Fh select global registers, whatever the device number. Indices 30h and above select the bank of device number register 07h: 30h bit 0 is activate, 60h/61h are base address high/low, 70h bits 3:0 are the interrupt select, and F0h is the option byte. A device number of NUM_LDEV or more reads FFh.
- R7: While bit 5 of register 26h (lock) is 1, data port writes are discarded, except writes to index 26h.
- R8: Register 02h is write-only and reads FFh. Writing it with bit 0 = 1 gives a one-cycle pulse on soft_rst_o.
- R9: Index 20h reads 71h and index 21h reads 20h.
- R10: After reset the file is closed, register 22h reads 80h, and registers 07h, 23h, 24h and 26h read 00h.
- R11: A data port read returns FFh while the file is closed, and also for any index that no register uses.
- R12: Bits that no field uses read as 0 and are not stored: 22h keeps bits 7:5, 23h keeps bits 7:4, 24h keeps bits 6:4, and 26h keeps bits 6:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational; FFh when not driven by a register |
| cfg_mode_o | output | 1 | File is open |
| ldn_o | output | 8 | Selected logical device number |
| pwr_en_o | output | 3 | Register 22h bits 7:5 |
| pme_en_o | output | 4 | Register 23h bits 7:4 |
| pme_sts_o | output | 3 | Register 24h bits 6:4 |
| port_hi_o | output | 1 | Port pair at 4Eh/4Fh |
| lock_o | output | 1 | Lock bit |
| soft_rst_o | output | 1 | Software reset pulse |
| dev_active_o | output | NUM_LDEV | Activate bit per device |
| dev_base_o | output | NUM_LDEV*16 | Base address per device, device 0 in the low bits |
| dev_irq_o | output | NUM_LDEV*4 | Interrupt select per device |
| dev_opt_o | output | NUM_LDEV*8 | Option byte per device |

## Verification
A key state that is wrong shows on cfg_mode_o one cycle after the write that should have moved it, and on io_rdata at once, because a closed file reads FFh. An index or device number that is wrong shows only when a later data port read returns another register's value, or when another device's parallel output changes. A lock or port-pair bit that is wrong shows as a register output that does not follow a data write in the next cycle. The bench therefore reads back through the data port after each write and also checks the parallel outputs.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;

    typedef enum logic [1:0] {
        KS_SHUT = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER = 8'h83;
    localparam logic [7:0] KEY_LEAVE = 8'hAA;
    localparam logic [7:0] RD_IDLE   = 8'hFF;

    localparam logic [9:0] PAIR_LO = 10'h02E;
    localparam logic [9:0] PAIR_HI = 10'h04E;

    localparam logic [7:0] IX_SWRST  = 8'h02;
    localparam logic [7:0] IX_LDN    = 8'h07;
    localparam logic [7:0] IX_ID_HI  = 8'h20;
    localparam logic [7:0] IX_ID_LO  = 8'h21;
    localparam logic [7:0] IX_PWR    = 8'h22;
    localparam logic [7:0] IX_PME    = 8'h23;
    localparam logic [7:0] IX_STS    = 8'h24;
    localparam logic [7:0] IX_GOPT   = 8'h26;
    localparam logic [7:0] IX_BANK0  = 8'h30;
    localparam logic [7:0] IX_BASE_H = 8'h60;
    localparam logic [7:0] IX_BASE_L = 8'h61;
    localparam logic [7:0] IX_IRQ    = 8'h70;
    localparam logic [7:0] IX_DOPT   = 8'hF0;

    localparam logic [7:0] ID_HI_VAL = 8'h71;
    localparam logic [7:0] ID_LO_VAL = 8'h20;

    typedef struct packed {
        logic        act;
        logic [15:0] base;
        logic [3:0]  irq;
        logic [7:0]  opt;
    } dev_cfg_t;

    function automatic logic [9:0] index_port(input logic hi);
        return hi ? PAIR_HI : PAIR_LO;
    endfunction

    function automatic logic is_global(input logic [7:0] ix);
        return ix < IX_BANK0;
    endfunction

endpackage

// File: rtl/cfgk_key_fsm.sv
module cfgk_key_fsm
    import cfgk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_any,
    input  logic       hit_index,
    input  logic [7:0] wdata,
    output logic       open_o
);
    key_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_SHUT;
        end else begin
            case (state_q)
                KS_SHUT: if (wr_any && hit_index && wdata == KEY_ENTER) state_q <= KS_HALF;
                KS_HALF: if (wr_any) state_q <= (hit_index && wdata == KEY_ENTER) ? KS_OPEN : KS_SHUT;
                KS_OPEN: if (wr_any && hit_index && wdata == KEY_LEAVE) state_q <= KS_SHUT;
                default: state_q <= KS_SHUT;
            endcase
        end
    end

    assign open_o = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgk_global_regs.sv
module cfgk_global_regs
    import cfgk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] ldn_q,
    output logic [2:0] pwr_q,
    output logic [3:0] pme_q,
    output logic [2:0] sts_q,
    output logic       port_hi_q,
    output logic       lock_q,
    output logic       swrst_q,
    output logic [7:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ldn_q     <= '0;
            pwr_q     <= 3'b100;
            pme_q     <= '0;
            sts_q     <= '0;
            port_hi_q <= 1'b0;
            lock_q    <= 1'b0;
            swrst_q   <= 1'b0;
        end else begin
            swrst_q <= wr_en && (index == IX_SWRST) && wdata[0];
            if (wr_en) begin
                case (index)
                    IX_LDN:  ldn_q <= wdata;
                    IX_PWR:  pwr_q <= wdata[7:5];
                    IX_PME:  pme_q <= wdata[7:4];
                    IX_STS:  sts_q <= wdata[6:4];
                    IX_GOPT: begin
                        port_hi_q <= wdata[6];
                        lock_q    <= wdata[5];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (index)
            IX_LDN:   rdata = ldn_q;
            IX_ID_HI: rdata = ID_HI_VAL;
            IX_ID_LO: rdata = ID_LO_VAL;
            IX_PWR:   rdata = {pwr_q, 5'b0};
            IX_PME:   rdata = {pme_q, 4'b0};
            IX_STS:   rdata = {1'b0, sts_q, 4'b0};
            IX_GOPT:  rdata = {1'b0, port_hi_q, lock_q, 5'b0};
            default:  rdata = RD_IDLE;
        endcase
    end
endmodule

// File: rtl/cfgk_dev_bank.sv
module cfgk_dev_bank
    import cfgk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output dev_cfg_t   cfg_q,
    output logic [7:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (index)
                IX_BANK0:  cfg_q.act        <= wdata[0];
                IX_BASE_H: cfg_q.base[15:8] <= wdata;
                IX_BASE_L: cfg_q.base[7:0]  <= wdata;
                IX_IRQ:    cfg_q.irq        <= wdata[3:0];
                IX_DOPT:   cfg_q.opt        <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (index)
            IX_BANK0:  rdata = {7'b0, cfg_q.act};
            IX_BASE_H: rdata = cfg_q.base[15:8];
            IX_BASE_L: rdata = cfg_q.base[7:0];
            IX_IRQ:    rdata = {4'b0, cfg_q.irq};
            IX_DOPT:   rdata = cfg_q.opt;
            default:   rdata = RD_IDLE;
        endcase
    end
endmodule

// File: rtl/cfgk_key_port.sv
module cfgk_key_port
    import cfgk_pkg::*;
#(
    parameter int NUM_LDEV = 4,
    parameter int ADDR_W   = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic                   cfg_mode_o,
    output logic [7:0]             ldn_o,
    output logic [2:0]             pwr_en_o,
    output logic [3:0]             pme_en_o,
    output logic [2:0]             pme_sts_o,
    output logic                   port_hi_o,
    output logic                   lock_o,
    output logic                   soft_rst_o,
    output logic [NUM_LDEV-1:0]    dev_active_o,
    output logic [NUM_LDEV*16-1:0] dev_base_o,
    output logic [NUM_LDEV*4-1:0]  dev_irq_o,
    output logic [NUM_LDEV*8-1:0]  dev_opt_o
);
    localparam logic [ADDR_W-1:0] A_LO_IX = ADDR_W'(PAIR_LO);
    localparam logic [ADDR_W-1:0] A_HI_IX = ADDR_W'(PAIR_HI);

    logic [ADDR_W-1:0] ix_addr, dat_addr;
    logic              hit_index, hit_data;
    logic              open_w;
    logic [7:0]        index_q;
    logic              data_wr;
    logic [7:0]        glob_rd;
    logic [7:0]        bank_rd;
    logic [7:0]        sel_rd;
    logic [7:0]        dev_rd [NUM_LDEV];
    dev_cfg_t          dev_cfg [NUM_LDEV];

    assign ix_addr   = port_hi_o ? A_HI_IX : A_LO_IX;
    assign dat_addr  = ix_addr + ADDR_W'(1);
    assign hit_index = (io_addr == ix_addr);
    assign hit_data  = (io_addr == dat_addr);

    cfgk_key_fsm key_i (
        .clk       (clk),
        .rst       (rst),
        .wr_any    (io_wr),
        .hit_index (hit_index),
        .wdata     (io_wdata),
        .open_o    (open_w)
    );
    assign cfg_mode_o = open_w;

    always_ff @(posedge clk) begin
        if (rst)
            index_q <= '0;
        else if (open_w && io_wr && hit_index && io_wdata != KEY_LEAVE)
            index_q <= io_wdata;
    end

    assign data_wr = open_w && io_wr && hit_data && (!lock_o || index_q == IX_GOPT);

    cfgk_global_regs glob_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (data_wr && is_global(index_q)),
        .index     (index_q),
        .wdata     (io_wdata),
        .ldn_q     (ldn_o),
        .pwr_q     (pwr_en_o),
        .pme_q     (pme_en_o),
        .sts_q     (pme_sts_o),
        .port_hi_q (port_hi_o),
        .lock_q    (lock_o),
        .swrst_q   (soft_rst_o),
        .rdata     (glob_rd)
    );

    for (genvar d = 0; d < NUM_LDEV; d++) begin : g_bank
        cfgk_dev_bank bank_i (
            .clk   (clk),
            .rst   (rst),
            .wr_en (data_wr && !is_global(index_q) && ldn_o == 8'(d)),
            .index (index_q),
            .wdata (io_wdata),
            .cfg_q (dev_cfg[d]),
            .rdata (dev_rd[d])
        );
        assign dev_active_o[d]        = dev_cfg[d].act;
        assign dev_base_o[d*16 +: 16] = dev_cfg[d].base;
        assign dev_irq_o[d*4 +: 4]    = dev_cfg[d].irq;
        assign dev_opt_o[d*8 +: 8]    = dev_cfg[d].opt;
    end

    always_comb begin
        bank_rd = RD_IDLE;
        for (int d = 0; d < NUM_LDEV; d++)
            if (ldn_o == 8'(d)) bank_rd = dev_rd[d];
    end

    assign sel_rd   = is_global(index_q) ? glob_rd : bank_rd;
    assign io_rdata = (io_rd && open_w && hit_data) ? sel_rd : RD_IDLE;
endmodule

// File: rtl/cfgk_checker.sv
module cfgk_checker
    import cfgk_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_mode_o,
    input logic [7:0]        ldn_o,
    input logic [2:0]        pwr_en_o,
    input logic              port_hi_o,
    input logic              lock_o,
    input logic              soft_rst_o
);
    logic [ADDR_W-1:0] exp_ix;
    assign exp_ix = ADDR_W'(index_port(port_hi_o));

    assert_key_entry_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode_o) |-> $past(io_wr && io_wdata == KEY_ENTER && io_addr == exp_ix));

    assert_leave_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode_o && io_wr && io_addr == exp_ix && io_wdata == KEY_LEAVE) |=> !cfg_mode_o);

    assert_closed_write_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode_o |=> ($stable(ldn_o) && $stable(pwr_en_o) && $stable(lock_o)));

    assert_closed_read_R11: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !cfg_mode_o) |-> io_rdata == RD_IDLE);

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_o && cfg_mode_o) |=> ($stable(ldn_o) && $stable(pwr_en_o)));

    assert_swrst_src_R8: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |-> $past(cfg_mode_o && io_wr));
endmodule

bind cfgk_key_port cfgk_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_mode_o (cfg_mode_o),
    .ldn_o      (ldn_o),
    .pwr_en_o   (pwr_en_o),
    .port_hi_o  (port_hi_o),
    .lock_o     (lock_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/cfgk_key_port_tb.sv
module cfgk_key_port_tb_top;
    localparam int N  = 4;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] io_addr = '0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          cfg_mode_o, port_hi_o, lock_o, soft_rst_o;
    logic [7:0]    ldn_o;
    logic [2:0]    pwr_en_o, pme_sts_o;
    logic [3:0]    pme_en_o;
    logic [N-1:0]    dev_active_o;
    logic [N*16-1:0] dev_base_o;
    logic [N*4-1:0]  dev_irq_o;
    logic [N*8-1:0]  dev_opt_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] ixa = 10'h02E;
    logic [AW-1:0] dta = 10'h02F;

    always #10 clk = ~clk;

    cfgk_key_port #(.NUM_LDEV(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode_o(cfg_mode_o),
        .ldn_o(ldn_o), .pwr_en_o(pwr_en_o), .pme_en_o(pme_en_o),
        .pme_sts_o(pme_sts_o), .port_hi_o(port_hi_o), .lock_o(lock_o),
        .soft_rst_o(soft_rst_o), .dev_active_o(dev_active_o),
        .dev_base_o(dev_base_o), .dev_irq_o(dev_irq_o), .dev_opt_o(dev_opt_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic setr(input logic [7:0] ix, input logic [7:0] v);
        wr(ixa, ix); wr(dta, v);
    endtask

    task automatic getr(input logic [7:0] ix, output logic [7:0] v);
        wr(ixa, ix); rd(dta, v);
    endtask

    task automatic enter();
        wr(ixa, 8'h83); wr(ixa, 8'h83);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R10 closed after reset", cfg_mode_o, 0);
        rd(dta, v);
        check("R11 closed read", v, 8'hFF);
        enter();
        check("R1 opened", cfg_mode_o, 1);
        getr(8'h22, v); check("R10 reg22 default", v, 8'h80);
        getr(8'h07, v); check("R10 reg07 default", v, 8'h00);
        getr(8'h23, v); check("R10 reg23 default", v, 8'h00);
        getr(8'h24, v); check("R10 reg24 default", v, 8'h00);
        getr(8'h26, v); check("R10 reg26 default", v, 8'h00);
        wr(ixa, 8'hAA);
    endtask

    task automatic t_restart();
        wr(ixa, 8'h83);
        check("R1 one key not enough", cfg_mode_o, 0);
        wr(dta, 8'h00);
        wr(ixa, 8'h83);
        check("R2 interrupted key", cfg_mode_o, 0);
        wr(ixa, 8'h83);
        check("R2 fresh pair opens", cfg_mode_o, 1);
    endtask

    task automatic t_globals();
        logic [7:0] v;
        getr(8'h20, v); check("R9 id high", v, 8'h71);
        getr(8'h21, v); check("R9 id low", v, 8'h20);
        rd(ixa, v);     check("R5 index port reads FF", v, 8'hFF);
        getr(8'h02, v); check("R8 reg02 reads FF", v, 8'hFF);
        getr(8'h05, v); check("R11 unused index", v, 8'hFF);
        setr(8'h23, 8'hFF);
        check("R12 pme outputs", pme_en_o, 4'hF);
        rd(dta, v);     check("R12 reg23 reserved zero", v, 8'hF0);
        setr(8'h24, 8'hFF);
        rd(dta, v);     check("R12 reg24 reserved zero", v, 8'h70);
        setr(8'h22, 8'h3F);
        rd(dta, v);     check("R12 reg22 reserved zero", v, 8'h20);
        check("R5 pwr output", pwr_en_o, 3'b001);
        wr(ixa, 8'h02); wr(dta, 8'h01);
        check("R8 soft reset pulse", soft_rst_o, 1);
        @(negedge clk);
        check("R8 pulse one cycle", soft_rst_o, 0);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        setr(8'h07, 8'h01);
        setr(8'h60, 8'h12);
        setr(8'h61, 8'h34);
        setr(8'h70, 8'hF5);
        setr(8'h30, 8'hFF);
        setr(8'hF0, 8'h5A);
        check("R6 dev1 base out", dev_base_o[31:16], 16'h1234);
        check("R6 dev1 irq out", dev_irq_o[7:4], 4'h5);
        check("R6 dev1 active out", dev_active_o, 4'b0010);
        check("R6 dev1 opt out", dev_opt_o[15:8], 8'h5A);
        getr(8'h70, v); check("R12 irq reserved zero", v, 8'h05);
        getr(8'h30, v); check("R12 active reserved zero", v, 8'h01);
        setr(8'h07, 8'h00);
        getr(8'h60, v); check("R6 dev0 separate", v, 8'h00);
        setr(8'h07, 8'h07);
        getr(8'h30, v); check("R6 absent device", v, 8'hFF);
        getr(8'h22, v); check("R6 globals any ldn", v, 8'h20);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        setr(8'h26, 8'h20);
        check("R7 lock set", lock_o, 1);
        setr(8'h22, 8'hE0);
        check("R7 locked write dropped", pwr_en_o, 3'b001);
        setr(8'h07, 8'h01);
        check("R7 locked ldn kept", ldn_o, 8'h07);
        getr(8'h26, v); check("R7 lock readable", v, 8'h20);
        setr(8'h26, 8'h00);
        check("R7 lock cleared", lock_o, 0);
    endtask

    task automatic t_hefras();
        logic [7:0] v;
        setr(8'h26, 8'h40);
        check("R3 port_hi set", port_hi_o, 1);
        wr(10'h02E, 8'h22); wr(10'h02F, 8'h00);
        check("R3 old port ignored", pwr_en_o, 3'b001);
        ixa = 10'h04E; dta = 10'h04F;
        getr(8'h22, v); check("R3 new port read", v, 8'h20);
        wr(ixa, 8'hAA);
        check("R4 leave via new port", cfg_mode_o, 0);
        wr(10'h02E, 8'h83); wr(10'h02E, 8'h83);
        check("R3 old key ignored", cfg_mode_o, 0);
        enter();
        check("R3 key at new port", cfg_mode_o, 1);
        setr(8'h26, 8'h00);
        ixa = 10'h02E; dta = 10'h02F;
    endtask

    task automatic t_exit();
        logic [7:0] v;
        wr(ixa, 8'h22);
        wr(ixa, 8'hAA);
        check("R4 closed", cfg_mode_o, 0);
        wr(dta, 8'hE0);
        check("R4 closed write ignored", pwr_en_o, 3'b001);
        rd(dta, v);
        check("R11 closed read FF", v, 8'hFF);
        enter();
        rd(dta, v);
        check("R4 index kept, value kept", v, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_restart();
        t_globals();
        t_banks();
        t_lock();
        t_hefras();
        t_exit();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule